// File: doc/BRIEF.md
# Windowed Transmit/Receive Message Queue Pair

This block gives a host a pair of small message queues, one for transmit and one for receive, for a CAN-style controller. The host never addresses individual queue slots. For transmit it fills a fixed staging window with an identifier word, a length code and eight data bytes. It then writes 0xFF to a commit register, and the window contents become the newest queue entry. For receive it reads the oldest entry through a fixed read window and writes 0xFF to an advance register to discard that entry and expose the next one.

A drain port stands in for the bus engine. It shows the oldest transmit entry and removes it on a take strobe. A push port lets the bus side deliver received messages, including a 16-bit timestamp. The host sees transmit progress only as a count of unsent messages. It also sees a receive-empty flag, a sticky transmit-overflow flag, per-queue enables, and an interrupt enable/status pair that drives one interrupt line.

Register map (6-bit word address, 32-bit data):

| Address | Meaning |
|---|---|
| 0x00 | TX window identifier |
| 0x01 | TX window length |
| 0x02 | TX window data bytes 0-3 |
| 0x03 | TX window data bytes 4-7 |
| 0x04 | RX window identifier |
| 0x05 | RX window length |
| 0x06 | RX window data bytes 0-3 |
| 0x07 | RX window data bytes 4-7 |
| 0x08 | RX window timestamp |
| 0x09 | TX control |
| 0x0A | RX control |
| 0x0B | TX commit |
| 0x0C | RX advance |
| 0x0D | Interrupt enable |
| 0x0E | Interrupt status |

Data byte i occupies bits 8i+7:8i of the 64-bit payload.

Top module: `mfp_top`

## Requirements
- R1: After reset, TX control (0x09) reads 0, RX control (0x0A) reads 0x80, interrupt enable and status read 0, `tx_valid` is 0 and `irq` is 0.
- R2: Writing exactly 0xFF to the TX commit register (0x0B) while TX is enabled copies the window (identifier word stored unchanged: bit 31 extended, bit 30 remote, a standard identifier placed at bits 28:18; length in bits 3:0) into the queue. The drain port delivers entries in commit order. TX control bits 3:1 give the unsent count. Any other written value commits nothing.
- R3: A commit while four entries are unsent is ignored and sets the sticky overflow flag, TX control bit 5. The flag is cleared only by disabling TX.
- R4: An `rx_push` while RX is enabled and the queue is not full appends an entry. Entries are shown at the read window (0x04..0x08) oldest first, and writing 0xFF to 0x0C pops the head. RX control bit 7 is 1 exactly when the queue is empty. A push into a full queue is dropped.
- R5: Writing 0xFF to 0x0C while the receive queue is empty has no effect on the queue pointers.
- R6: Status bit 3 is set when a drain take removes an entry and status bit 4 is set when an entry is pushed, each only if the same bit of the enable register (0x0D) is 1. `irq` is the OR of the status bits.
- R7: Writing the status register clears each bit written as 0 and leaves each bit written as 1. An event in the same cycle as a clearing write leaves its bit set.
- R8: Writing 0 to bit 0 of a control register flushes that queue (unsent count 0 or empty flag 1). Commits or pushes while disabled are ignored.
- R9: A drain take and a commit in the same cycle leave the unsent count unchanged and preserve order. A push and a pop in the same cycle leave the receive occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 6 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 6 | Host read address |
| host_rdata | output | 32 | Host read data (combinational) |
| tx_valid | output | 1 | Transmit queue has an unsent entry |
| tx_ident | output | 32 | Head entry identifier word |
| tx_len | output | 4 | Head entry length code |
| tx_payload | output | 64 | Head entry data bytes |
| tx_take | input | 1 | Drain removes the head entry |
| rx_push | input | 1 | Bus side delivers a received entry |
| rx_ident | input | 32 | Received identifier word |
| rx_len | input | 4 | Received length code |
| rx_payload | input | 64 | Received data bytes |
| rx_stamp | input | 16 | Received timestamp |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a drain take and a host commit on the transmit queue. The second pair is a bus push and a host pop on the receive queue. The bench arms the drain for one take and lands the commit on the edge where that take lands. It also drives a push and a 0xFF advance write in the same cycle. The check is that the unsent count and the empty flag hold, and that the scoreboard sees entries leave in their arrival order. A push landing on a clearing status write is also provoked, and the status bit must stay set.

// File: rtl/mfp_pkg.sv
// Shared types and register addresses for the windowed message queue pair.
// Assumes a 6-bit word address and 32-bit host data.
package mfp_pkg;
    typedef struct packed {
        logic [31:0] ident;
        logic [3:0]  len;
        logic [63:0] payload;
    } mfp_txmsg_t;

    typedef struct packed {
        logic [31:0] ident;
        logic [3:0]  len;
        logic [63:0] payload;
        logic [15:0] stamp;
    } mfp_rxmsg_t;

    localparam int TX_W = $bits(mfp_txmsg_t);
    localparam int RX_W = $bits(mfp_rxmsg_t);

    localparam logic [5:0] A_TXID    = 6'h00;
    localparam logic [5:0] A_TXLEN   = 6'h01;
    localparam logic [5:0] A_TXDLO   = 6'h02;
    localparam logic [5:0] A_TXDHI   = 6'h03;
    localparam logic [5:0] A_RXID    = 6'h04;
    localparam logic [5:0] A_RXLEN   = 6'h05;
    localparam logic [5:0] A_RXDLO   = 6'h06;
    localparam logic [5:0] A_RXDHI   = 6'h07;
    localparam logic [5:0] A_RXSTAMP = 6'h08;
    localparam logic [5:0] A_TXCTL   = 6'h09;
    localparam logic [5:0] A_RXCTL   = 6'h0A;
    localparam logic [5:0] A_TXPTR   = 6'h0B;
    localparam logic [5:0] A_RXPTR   = 6'h0C;
    localparam logic [5:0] A_IE      = 6'h0D;
    localparam logic [5:0] A_IS      = 6'h0E;

    localparam logic [7:0] PTR_ADVANCE = 8'hFF;
    localparam int IRQ_TX_BIT = 3;
    localparam int IRQ_RX_BIT = 4;
endpackage

// File: rtl/mfp_fifo.sv
// Circular message queue with occupancy count and synchronous flush.
// Assumes: push when full and pop when empty are dropped; flush beats both.
module mfp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  slot [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot[rd_ptr];

    // Storage write: place accepted entries at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !flush) slot[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R3 / R4: a push into a full queue changes nothing.
    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> count == $past(count));
    // R5: a pop on an empty queue leaves it empty.
    a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !flush |=> empty);
    // R9: simultaneous accepted push and pop keep occupancy.
    a_r9_push_pop_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !full && !empty && !flush |=> count == $past(count));
    // R8: a flush empties the queue on the next edge.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/mfp_irq.sv
// Interrupt enable and status pair. Only the transmit and receive event bits
// exist. A status write clears the bits written as zero. A new event wins over
// a clear in the same cycle, and events set status only when enabled.
module mfp_irq
    import mfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ie_we,
    input  logic       is_we,
    input  logic [7:0] wdata,
    input  logic       tx_evt,
    input  logic       rx_evt,
    output logic [7:0] ie,
    output logic [7:0] is,
    output logic       irq
);
    localparam logic [7:0] IMPL = (8'd1 << IRQ_TX_BIT) | (8'd1 << IRQ_RX_BIT);

    logic [7:0] evt, keep;

    assign evt  = ({7'd0, tx_evt} << IRQ_TX_BIT) | ({7'd0, rx_evt} << IRQ_RX_BIT);
    assign keep = is_we ? (is & wdata) : is;
    assign irq  = |is;

    // Enable register: host-written, unimplemented bits read zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= '0;
        else if (ie_we) ie <= wdata & IMPL;
    end

    // Status register: clear-by-zero writes merged with gated events.
    always_ff @(posedge clk) begin
        if (!rst_n) is <= '0;
        else        is <= (keep | (evt & ie)) & IMPL;
    end

    // R6: an enabled transmit event sets its status bit.
    a_r6_tx_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && ie[IRQ_TX_BIT] |=> is[IRQ_TX_BIT]);
    // R6: a disabled receive event cannot raise its bit from zero.
    a_r6_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !is[IRQ_RX_BIT] && !ie[IRQ_RX_BIT] |=> !is[IRQ_RX_BIT]);
    // R7: writing one to a set bit keeps it.
    a_r7_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        is_we && wdata[IRQ_TX_BIT] && is[IRQ_TX_BIT] |=> is[IRQ_TX_BIT]);
    // R7: an enabled event beats a simultaneous clearing write.
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        is_we && !wdata[IRQ_RX_BIT] && rx_evt && ie[IRQ_RX_BIT] |=> is[IRQ_RX_BIT]);
endmodule

// File: rtl/mfp_top.sv
// Windowed transmit/receive message queue pair with register access.
// Assumes single-cycle host writes, combinational host reads, and that the
// drain/push ports act as the bus engine. Disabled queues are held flushed.
module mfp_top
    import mfp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [5:0]  host_waddr,
    input  logic [31:0] host_wdata,
    input  logic [5:0]  host_raddr,
    output logic [31:0] host_rdata,
    output logic        tx_valid,
    output logic [31:0] tx_ident,
    output logic [3:0]  tx_len,
    output logic [63:0] tx_payload,
    input  logic        tx_take,
    input  logic        rx_push,
    input  logic [31:0] rx_ident,
    input  logic [3:0]  rx_len,
    input  logic [63:0] rx_payload,
    input  logic [15:0] rx_stamp,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [31:0] win_id;
    logic [3:0]  win_len;
    logic [63:0] win_data;
    logic        tx_en, rx_en, tx_ovf;
    logic        commit, advance;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [2:0]  tx_cnt3;
    mfp_txmsg_t  tx_in, tx_head;
    mfp_rxmsg_t  rx_in, rx_head;
    logic        tx_evt, rx_evt;
    logic [7:0]  ie, is;

    assign commit  = host_we && host_waddr == A_TXPTR && host_wdata[7:0] == PTR_ADVANCE && tx_en;
    assign advance = host_we && host_waddr == A_RXPTR && host_wdata[7:0] == PTR_ADVANCE && rx_en;
    assign tx_in   = '{ident: win_id, len: win_len, payload: win_data};
    assign rx_in   = '{ident: rx_ident, len: rx_len, payload: rx_payload, stamp: rx_stamp};
    assign tx_evt  = tx_take && tx_valid;
    assign rx_evt  = rx_push && rx_en && !rx_full;
    assign tx_cnt3 = 3'(tx_cnt);

    // Transmit staging window: host fills it before a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_id   <= '0;
            win_len  <= '0;
            win_data <= '0;
        end else if (host_we) begin
            case (host_waddr)
                A_TXID:  win_id          <= host_wdata;
                A_TXLEN: win_len         <= host_wdata[3:0];
                A_TXDLO: win_data[31:0]  <= host_wdata;
                A_TXDHI: win_data[63:32] <= host_wdata;
                default: ;
            endcase
        end
    end

    // Queue enables: bit 0 of each control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (host_we) begin
            if (host_waddr == A_TXCTL) tx_en <= host_wdata[0];
            if (host_waddr == A_RXCTL) rx_en <= host_wdata[0];
        end
    end

    // Sticky overflow: set by a commit into a full queue, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)    tx_ovf <= 1'b0;
        else if (commit && tx_full) tx_ovf <= 1'b1;
    end

    mfp_fifo #(.DEPTH(DEPTH), .W(TX_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!tx_en),
        .push(commit), .din(tx_in), .pop(tx_take), .head(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    mfp_fifo #(.DEPTH(DEPTH), .W(RX_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en),
        .push(rx_push && rx_en), .din(rx_in), .pop(advance), .head(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    mfp_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .ie_we(host_we && host_waddr == A_IE),
        .is_we(host_we && host_waddr == A_IS),
        .wdata(host_wdata[7:0]),
        .tx_evt(tx_evt), .rx_evt(rx_evt),
        .ie(ie), .is(is), .irq(irq)
    );

    assign tx_valid   = !tx_empty;
    assign tx_ident   = tx_head.ident;
    assign tx_len     = tx_head.len;
    assign tx_payload = tx_head.payload;

    // Host read multiplexer.
    always_comb begin
        case (host_raddr)
            A_TXID:    host_rdata = win_id;
            A_TXLEN:   host_rdata = {28'd0, win_len};
            A_TXDLO:   host_rdata = win_data[31:0];
            A_TXDHI:   host_rdata = win_data[63:32];
            A_RXID:    host_rdata = rx_head.ident;
            A_RXLEN:   host_rdata = {28'd0, rx_head.len};
            A_RXDLO:   host_rdata = rx_head.payload[31:0];
            A_RXDHI:   host_rdata = rx_head.payload[63:32];
            A_RXSTAMP: host_rdata = {16'd0, rx_head.stamp};
            A_TXCTL:   host_rdata = {26'd0, tx_ovf, 1'b0, tx_cnt3, tx_en};
            A_RXCTL:   host_rdata = {24'd0, rx_empty, 6'd0, rx_en};
            A_IE:      host_rdata = {24'd0, ie};
            A_IS:      host_rdata = {24'd0, is};
            default:   host_rdata = '0;
        endcase
    end

    // R3: overflow only falls after TX was disabled.
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ovf) |-> !$past(tx_en));
    // R8: a queue disabled for two cycles offers nothing to the drain.
    a_r8_disabled_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en && !$past(tx_en) |-> !tx_valid);
    // R2: a commit into a non-full queue makes an entry available.
    a_r2_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !tx_full |=> tx_valid);
    // R6: irq follows the status bits.
    a_r6_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (is != 8'd0));
endmodule

// File: tb/sim_mfp_top.sv
`timescale 1ns/1ps
module sim_mfp_top;
    import mfp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [5:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        tx_valid;
    logic [31:0] tx_ident;
    logic [3:0]  tx_len;
    logic [63:0] tx_payload;
    logic        tx_take = 1'b0;
    logic        rx_push = 1'b0;
    logic [31:0] rx_ident = '0;
    logic [3:0]  rx_len = '0;
    logic [63:0] rx_payload = '0;
    logic [15:0] rx_stamp = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit drain_on = 0;
    bit drain_once = 0;
    logic [99:0]  txq[$];
    logic [115:0] rxq[$];

    always #2 clk = ~clk;

    mfp_top u0 (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_raddr = a;
        #0.5;
        d = host_rdata;
    endtask

    task automatic rd_check(string tag, logic [5:0] a, logic [31:0] exp);
        logic [31:0] v;
        host_rd(a, v);
        check(tag, {32'd0, v}, {32'd0, exp});
    endtask

    task automatic tx_load(logic [31:0] id, logic [3:0] len, logic [63:0] d);
        host_wr(A_TXID, id);
        host_wr(A_TXLEN, {28'd0, len});
        host_wr(A_TXDLO, d[31:0]);
        host_wr(A_TXDHI, d[63:32]);
    endtask

    // Driver: commit and record the expected drained item.
    task automatic tx_send(logic [31:0] id, logic [3:0] len, logic [63:0] d, bit accepted);
        tx_load(id, len, d);
        host_wr(A_TXPTR, 32'hFF);
        if (accepted) txq.push_back({id, len, d});
    endtask

    task automatic rx_feed(logic [31:0] id, logic [3:0] len, logic [63:0] d,
                           logic [15:0] ts, bit accepted);
        @(negedge clk);
        rx_push = 1'b1; rx_ident = id; rx_len = len; rx_payload = d; rx_stamp = ts;
        @(negedge clk);
        rx_push = 1'b0;
        if (accepted) rxq.push_back({id, len, d, ts});
    endtask

    // Host write and bus push landing on the same edge.
    task automatic feed_with_write(logic [31:0] id, logic [15:0] ts,
                                   logic [5:0] a, logic [31:0] wd);
        @(negedge clk);
        rx_push = 1'b1; rx_ident = id; rx_len = 4'd1; rx_payload = 64'h5A; rx_stamp = ts;
        host_we = 1'b1; host_waddr = a; host_wdata = wd;
        @(negedge clk);
        rx_push = 1'b0; host_we = 1'b0;
        rxq.push_back({id, 4'd1, 64'h5A, ts});
    endtask

    // Read the head through the window, compare with the scoreboard, then pop.
    task automatic rx_take_check(string tag);
        logic [31:0] a, b, c, e, f;
        logic [115:0] exp;
        host_rd(A_RXID, a);
        host_rd(A_RXLEN, b);
        host_rd(A_RXDLO, c);
        host_rd(A_RXDHI, e);
        host_rd(A_RXSTAMP, f);
        if (rxq.size() == 0) begin
            check({tag, " rx scoreboard empty"}, 64'd1, 64'd0);
        end else begin
            exp = rxq.pop_front();
            check({tag, " rx ident"}, {32'd0, a}, {32'd0, exp[115:84]});
            check({tag, " rx len/stamp"}, {28'd0, b[3:0], 16'd0, f[15:0]},
                  {28'd0, exp[83:80], 16'd0, exp[15:0]});
            check({tag, " rx data"}, {e, c}, exp[79:16]);
        end
        host_wr(A_RXPTR, 32'hFF);
    endtask

    task automatic wait_drained();
        for (int i = 0; i < 40 && txq.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", 64'(txq.size()), 64'd0);
    endtask

    // Monitor: after each edge, drain the head if allowed and compare it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if ((drain_on || drain_once) && tx_valid) begin
                drain_once = 0;
                if (txq.size() == 0) begin
                    check("R2 unexpected drain", {32'd0, tx_ident}, 64'd0);
                end else begin
                    logic [99:0] exp;
                    exp = txq.pop_front();
                    check("R2 drain ident/len", {28'd0, tx_len, tx_ident},
                          {28'd0, exp[67:64], exp[99:68]});
                    check("R2 drain data", tx_payload, exp[63:0]);
                end
                tx_take = 1'b1;
            end else begin
                tx_take = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 txctl", A_TXCTL, 32'h0);
        rd_check("R1 rxctl", A_RXCTL, 32'h80);
        rd_check("R1 ie", A_IE, 32'h0);
        rd_check("R1 is", A_IS, 32'h0);
        check("R1 tx_valid/irq", {62'd0, tx_valid, irq}, 64'd0);

        host_wr(A_TXCTL, 32'h1);
        host_wr(A_RXCTL, 32'h1);
        host_wr(A_IE, 32'h18);

        // R2 commit: standard id at bit 18, extended (bit 31), remote (bit 30)
        tx_send(32'h123 << 18, 4'd8, 64'h8877665544332211, 1);
        tx_send(32'h80000000 | 32'h1ABCDEF, 4'd3, 64'h0000000000CCBBAA, 1);
        tx_send(32'h40000000 | (32'h7FF << 18), 4'd0, 64'h0, 1);
        rd_check("R2 unsent three", A_TXCTL, 32'h7);
        host_wr(A_TXPTR, 32'h12);
        rd_check("R2 non-FF commit ignored", A_TXCTL, 32'h7);

        // R3 fill to four, then overflow
        tx_send(32'h055 << 18, 4'd2, 64'hBEEF, 1);
        rd_check("R3 unsent four", A_TXCTL, 32'h9);
        tx_send(32'h066 << 18, 4'd1, 64'h77, 0);
        rd_check("R3 overflow flagged, count held", A_TXCTL, 32'h29);

        // R2 / R6 drain in order, transmit event raised
        drain_on = 1;
        wait_drained();
        drain_on = 0;
        rd_check("R3 overflow sticky after drain", A_TXCTL, 32'h21);
        rd_check("R6 tx status bit", A_IS, 32'h08);
        check("R6 irq high", {63'd0, irq}, 64'd1);

        // R7 write-one keeps, write-zero clears
        host_wr(A_IS, 32'h08);
        rd_check("R7 one keeps", A_IS, 32'h08);
        host_wr(A_IS, 32'h00);
        rd_check("R7 zero clears", A_IS, 32'h00);
        check("R7 irq low", {63'd0, irq}, 64'd0);

        // R3 disable clears overflow
        host_wr(A_TXCTL, 32'h0);
        repeat (2) @(negedge clk);
        host_wr(A_TXCTL, 32'h1);
        rd_check("R3 overflow cleared by disable", A_TXCTL, 32'h1);

        // R4 receive order and empty flag
        rd_check("R4 rx empty", A_RXCTL, 32'h81);
        rx_feed(32'h80000000 | 32'h00ABCDE, 4'd5, 64'h1122334455, 16'h1001, 1);
        rx_feed(32'h3C << 18, 4'd8, 64'hF0E0D0C0B0A09080, 16'h2002, 1);
        rd_check("R4 rx not empty", A_RXCTL, 32'h01);
        rd_check("R6 rx status bit", A_IS, 32'h10);
        rx_take_check("R4 first");
        rx_take_check("R4 second");
        rd_check("R4 rx empty again", A_RXCTL, 32'h81);

        // R5 pop on empty, then a push must show at the head
        host_wr(A_RXPTR, 32'hFF);
        rd_check("R5 still empty", A_RXCTL, 32'h81);
        rx_feed(32'h2A << 18, 4'd1, 64'h99, 16'h3003, 1);
        rx_take_check("R5 after empty pop");
        rd_check("R5 empty after single pop", A_RXCTL, 32'h81);

        // R4 full receive drops fifth
        for (int i = 0; i < 5; i++)
            rx_feed(32'(i + 1) << 18, 4'(i), 64'(i * 3 + 7), 16'(i + 40), i < 4);
        for (int i = 0; i < 4; i++) rx_take_check("R4 full order");
        rd_check("R4 fifth dropped", A_RXCTL, 32'h81);

        // R7 event beats simultaneous clearing write
        host_wr(A_IS, 32'h00);
        feed_with_write(32'h11 << 18, 16'h4004, A_IS, 32'h00);
        rd_check("R7 event wins over clear", A_IS, 32'h10);
        rx_take_check("R7 entry");

        // R9 receive push and pop same cycle
        rx_feed(32'h21 << 18, 4'd2, 64'h4242, 16'h5005, 1);
        feed_with_write(32'h22 << 18, 16'h6006, A_RXPTR, 32'hFF);
        void'(rxq.pop_front());
        rd_check("R9 rx occupancy held", A_RXCTL, 32'h01);
        rx_take_check("R9 rx new head");
        rd_check("R9 rx empty after", A_RXCTL, 32'h81);

        // R9 transmit take and commit same cycle
        tx_send(32'h31 << 18, 4'd4, 64'hA1A2A3A4, 1);
        tx_send(32'h32 << 18, 4'd4, 64'hB1B2B3B4, 1);
        tx_load(32'h33 << 18, 4'd6, 64'hC1C2C3C4C5C6);
        @(negedge clk);
        drain_once = 1;
        host_wr(A_TXPTR, 32'hFF);
        txq.push_back({32'h33 << 18, 4'd6, 64'hC1C2C3C4C5C6});
        rd_check("R9 unsent held at two", A_TXCTL, 32'h5);
        drain_on = 1;
        wait_drained();
        drain_on = 0;

        // R8 flush on disable, commits and pushes ignored while off
        tx_send(32'h41 << 18, 4'd1, 64'h1, 0);
        tx_send(32'h42 << 18, 4'd1, 64'h2, 0);
        host_wr(A_TXCTL, 32'h0);
        repeat (2) @(negedge clk);
        rd_check("R8 tx flushed", A_TXCTL, 32'h0);
        check("R8 tx_valid low", {63'd0, tx_valid}, 64'd0);
        host_wr(A_TXPTR, 32'hFF);
        host_wr(A_TXCTL, 32'h1);
        rd_check("R8 commit while off ignored", A_TXCTL, 32'h1);
        rx_feed(32'h43 << 18, 4'd1, 64'h3, 16'h7, 0);
        host_wr(A_RXCTL, 32'h0);
        repeat (2) @(negedge clk);
        rx_feed(32'h44 << 18, 4'd1, 64'h4, 16'h8, 0);
        host_wr(A_RXCTL, 32'h1);
        rd_check("R8 rx flushed, push while off ignored", A_RXCTL, 32'h81);

        // R6 receive event gated by enable
        host_wr(A_IS, 32'h00);
        host_wr(A_IE, 32'h08);
        rx_feed(32'h45 << 18, 4'd1, 64'h5, 16'h9, 1);
        rd_check("R6 gated rx status", A_IS, 32'h00);
        check("R6 irq stays low", {63'd0, irq}, 64'd0);
        rx_take_check("R6 entry");

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule